// File: doc/BRIEF.md
# Multifunction Capture/Compare Timer

A timer block built around one free-running up-counter that advances on ticks from a programmable clock divider. The same counter serves two independent channels, and each channel either captures the counter on an edge of its input pin or drives its output pin when the counter reaches a programmed value. Two alternate counting modes reuse the counter. In pulse mode it counts edges of an external pulse input. In PWM mode it runs from zero up to a programmable period and drives a PWM pin from a duty value.

Software reaches the block through a flat register port. Writes are single-cycle strobes. Reads are combinational from the addressed register. Register words are `CNT_W` bits wide and sit at these word addresses: control 0, counter 1, PWM period 2, PWM duty 3, and per channel `i` a configuration word at 4+2i and a value word at 5+2i. With two channels, status is at 8 and interrupt enables are at 9. Control fields are: bit 0 run, bit 1 PWM mode, bit 2 pulse mode, bit 3 pulse falling-edge select, and bits 10:4 the prescale value. The status word holds bit 0 overflow, bits 1..NUM_CH the channel event flags, and bits NUM_CH+1..2·NUM_CH the channel overrun bits. A single interrupt line is the masked OR of the event flags.

Top module: `mct_timer`

## Requirements
- R1: After reset the counter reads 0, the status word reads 0, and `cmp_o`, `pwm_o` and `irq_o` are all low.
- R2: The counter changes only while the run bit is 1. With run at 1 and pulse mode off, the counter advances once every P+1 clocks, where P is the prescale field (0..127). Clearing run freezes the counter. A write to address 1 loads the counter directly.
- R3: In free-running mode the counter wraps from all ones to 0. The clock edge that performs the wrap sets status bit 0.
- R4: When the pulse mode bit is set, the counter ignores the prescaler. Instead it advances once for each edge of `pulse_i` after that edge passes a two-stage synchroniser. Control bit 3 selects the edge: 0 counts rising edges and 1 counts falling edges. Edges of the other polarity are ignored.
- R5: With configuration bit 0 clear, a channel is in capture mode. Configuration bit 1 selects the edge of `cap_i[i]`: 0 rising, 1 falling. If the pin changes just before clock edge A, the value word latches the counter value held after edge A+1, and status bit 1+i is set. Edges of the unselected polarity change nothing.
- R6: A capture on a channel whose event flag is still set also sets status bit 1+NUM_CH+i.
- R7: With configuration bit 0 set, a channel is in compare mode. On the clock edge where the counter advances away from a value equal to the channel's value word, the channel applies its action to `cmp_o[i]` and sets status bit 1+i. The action is held in configuration bits 3:2: 01 drives the pin high, 10 drives it low, 11 toggles it, and 00 leaves it unchanged.
- R8: When PWM mode is set, the counter counts 0..period and then restarts at 0. `pwm_o` is high while the counter is below the duty value. `pwm_o` is low whenever PWM mode is off.
- R9: A period or duty write made while PWM mode is running takes effect only at the next restart to 0. While PWM mode is off, written values take effect immediately.
- R10: `irq_o` is the OR of the overflow flag and the channel event flags, each gated by its enable bit (enable bit 0 for overflow, enable bit 1+i for channel i). Overrun bits never raise the interrupt.
- R11: Writing the status word clears each bit that is written as 1 and leaves each bit that is written as 0 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Register word address |
| bus_wdata_i | input | CNT_W | Write data |
| bus_rdata_o | output | CNT_W | Read data for the addressed register |
| cap_i | input | NUM_CH | Capture inputs, one per channel, asynchronous |
| pulse_i | input | 1 | External pulse input for pulse mode, asynchronous |
| cmp_o | output | NUM_CH | Compare outputs, one per channel |
| pwm_o | output | 1 | PWM output |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the timer with its defaults: CNT_W=16, PRE_W=7, NUM_CH=2, ADDR_W=4. Because the counter is 16 bits and can be loaded directly, the bench seeds it near all ones and reaches the wrap in a few cycles. The 7-bit prescaler lets both extreme divisors (1 and 128) and random values in between run to completion within a few hundred clocks each. With two channels, a rising-edge capture and a falling-edge capture can fire on the same clock, and a set action and a toggle action can be checked side by side on separate pins.

// File: rtl/mct_pkg.sv
package mct_pkg;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_SET  = 2'd1,
    ACT_CLR  = 2'd2,
    ACT_TGL  = 2'd3
  } cmp_act_e;

  typedef struct packed {
    cmp_act_e act;
    logic     cap_fall;
    logic     is_cmp;
  } ch_cfg_t;

  localparam int unsigned CFG_W = $bits(ch_cfg_t);

endpackage

// File: rtl/mct_sync_edge.sv
module mct_sync_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  input  logic fall_sel_i,
  output logic edge_o
);
  // [0] metastable stage, [1] synchronised, [2] previous
  logic [2:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[1:0], d_i};
  end

  assign edge_o = fall_sel_i ? (sr_q[2] & ~sr_q[1]) : (sr_q[1] & ~sr_q[2]);

endmodule

// File: rtl/mct_prescaler.sv
module mct_prescaler #(
  parameter int unsigned PRE_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [PRE_W-1:0] presc_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] div_q;

  assign tick_o = en_i && (div_q >= presc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     div_q <= '0;
    else if (!en_i)  div_q <= '0;
    else if (tick_o) div_q <= '0;
    else             div_q <= div_q + 1'b1;
  end

  AST_PRESC_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && presc_i != '0) |=> (!tick_o || presc_i == '0)); // R2

endmodule

// File: rtl/mct_channel.sv
module mct_channel
  import mct_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic             val_we_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             tick_i,
  input  logic             cap_i,
  input  logic             clr_flag_i,
  input  logic             clr_ovr_i,
  output ch_cfg_t          cfg_o,
  output logic [CNT_W-1:0] val_o,
  output logic             flag_o,
  output logic             ovr_o,
  output logic             cmp_o
);
  ch_cfg_t          cfg_q;
  logic [CNT_W-1:0] val_q;
  logic             flag_q, ovr_q, cmp_q;
  logic             cap_edge, cap_evt, cmp_evt;

  mct_sync_edge i_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .d_i        (cap_i),
    .fall_sel_i (cfg_q.cap_fall),
    .edge_o     (cap_edge)
  );

  assign cap_evt = !cfg_q.is_cmp && cap_edge;
  assign cmp_evt = cfg_q.is_cmp && tick_i && (cnt_i == val_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      val_q  <= '0;
      flag_q <= 1'b0;
      ovr_q  <= 1'b0;
      cmp_q  <= 1'b0;
    end else begin
      if (cfg_we_i) cfg_q <= ch_cfg_t'(wdata_i[CFG_W-1:0]);

      if (cap_evt)       val_q <= cnt_i;
      else if (val_we_i) val_q <= wdata_i;

      if (cap_evt || cmp_evt) flag_q <= 1'b1;
      else if (clr_flag_i)    flag_q <= 1'b0;

      if (cap_evt && flag_q) ovr_q <= 1'b1;
      else if (clr_ovr_i)    ovr_q <= 1'b0;

      if (cmp_evt) begin
        case (cfg_q.act)
          ACT_SET: cmp_q <= 1'b1;
          ACT_CLR: cmp_q <= 1'b0;
          ACT_TGL: cmp_q <= ~cmp_q;
          default: cmp_q <= cmp_q;
        endcase
      end
    end
  end

  assign cfg_o  = cfg_q;
  assign val_o  = val_q;
  assign flag_o = flag_q;
  assign ovr_o  = ovr_q;
  assign cmp_o  = cmp_q;

  AST_CAP_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_evt |=> (val_q == $past(cnt_i))); // R5
  AST_EVT_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_evt || cmp_evt) |=> flag_q); // R5
  AST_OVR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_evt && flag_q) |=> ovr_q); // R6
  AST_CMP_TGL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_evt && cfg_q.act == ACT_TGL) |=> (cmp_q != $past(cmp_q))); // R7
  AST_CMP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmp_evt |=> $stable(cmp_q)); // R7

endmodule

// File: rtl/mct_timer.sv
module mct_timer
  import mct_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned PRE_W  = 7,
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [CNT_W-1:0]  bus_wdata_i,
  output logic [CNT_W-1:0]  bus_rdata_o,
  input  logic [NUM_CH-1:0] cap_i,
  input  logic              pulse_i,
  output logic [NUM_CH-1:0] cmp_o,
  output logic              pwm_o,
  output logic              irq_o
);
  localparam int unsigned A_CTRL = 0;
  localparam int unsigned A_CNT  = 1;
  localparam int unsigned A_PER  = 2;
  localparam int unsigned A_DUTY = 3;
  localparam int unsigned A_CH0  = 4;
  localparam int unsigned A_STAT = A_CH0 + 2 * NUM_CH;
  localparam int unsigned A_IEN  = A_STAT + 1;
  localparam int unsigned B_RUN  = 0;
  localparam int unsigned B_PWM  = 1;
  localparam int unsigned B_PLS  = 2;
  localparam int unsigned B_PFL  = 3;
  localparam int unsigned B_PRE  = 4;
  localparam int unsigned CTRL_W = B_PRE + PRE_W;
  localparam int unsigned ST_W   = 1 + 2 * NUM_CH;

  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  cnt_q, per_sh, duty_sh, per_act, duty_act;
  logic [NUM_CH:0]   ien_q;
  logic              ovf_q;
  logic [NUM_CH-1:0] ch_flag, ch_ovr, clr_flag, clr_ovr;
  logic [CNT_W-1:0]  ch_val [NUM_CH];
  ch_cfg_t           ch_cfg [NUM_CH];

  logic run, pwm_mode, pulse_mode, pre_tick, pulse_edge, tick;
  logic cnt_we, st_clr, reload, ovf_evt;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned r);
    return a == ADDR_W'(r);
  endfunction

  assign run        = ctrl_q[B_RUN];
  assign pwm_mode   = ctrl_q[B_PWM];
  assign pulse_mode = ctrl_q[B_PLS];
  assign cnt_we     = bus_we_i && hit(bus_addr_i, A_CNT);
  assign st_clr     = bus_we_i && hit(bus_addr_i, A_STAT);

  mct_prescaler #(.PRE_W(PRE_W)) i_presc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (run && !pulse_mode),
    .presc_i (ctrl_q[B_PRE +: PRE_W]),
    .tick_o  (pre_tick)
  );

  mct_sync_edge i_pulse (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .d_i        (pulse_i),
    .fall_sel_i (ctrl_q[B_PFL]),
    .edge_o     (pulse_edge)
  );

  assign tick    = run && (pulse_mode ? pulse_edge : pre_tick);
  assign reload  = tick && pwm_mode && !cnt_we && (cnt_q >= per_act);
  assign ovf_evt = tick && !pwm_mode && !cnt_we && (cnt_q == '1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      cnt_q    <= '0;
      per_sh   <= '0;
      duty_sh  <= '0;
      per_act  <= '0;
      duty_act <= '0;
      ien_q    <= '0;
      ovf_q    <= 1'b0;
    end else begin
      if (bus_we_i && hit(bus_addr_i, A_CTRL)) ctrl_q  <= bus_wdata_i[CTRL_W-1:0];
      if (bus_we_i && hit(bus_addr_i, A_PER))  per_sh  <= bus_wdata_i;
      if (bus_we_i && hit(bus_addr_i, A_DUTY)) duty_sh <= bus_wdata_i;
      if (bus_we_i && hit(bus_addr_i, A_IEN))  ien_q   <= bus_wdata_i[NUM_CH:0];

      if (cnt_we)      cnt_q <= bus_wdata_i;
      else if (reload) cnt_q <= '0;
      else if (tick)   cnt_q <= cnt_q + 1'b1;

      // shadow values follow freely outside PWM, latch only at restart inside it
      if (!pwm_mode || reload) begin
        per_act  <= per_sh;
        duty_act <= duty_sh;
      end

      if (ovf_evt)                     ovf_q <= 1'b1;
      else if (st_clr && bus_wdata_i[0]) ovf_q <= 1'b0;
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign clr_flag[i] = st_clr && bus_wdata_i[1 + i];
    assign clr_ovr[i]  = st_clr && bus_wdata_i[1 + NUM_CH + i];

    mct_channel #(.CNT_W(CNT_W)) i_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cfg_we_i   (bus_we_i && hit(bus_addr_i, A_CH0 + 2 * i)),
      .val_we_i   (bus_we_i && hit(bus_addr_i, A_CH0 + 2 * i + 1)),
      .wdata_i    (bus_wdata_i),
      .cnt_i      (cnt_q),
      .tick_i     (tick),
      .cap_i      (cap_i[i]),
      .clr_flag_i (clr_flag[i]),
      .clr_ovr_i  (clr_ovr[i]),
      .cfg_o      (ch_cfg[i]),
      .val_o      (ch_val[i]),
      .flag_o     (ch_flag[i]),
      .ovr_o      (ch_ovr[i]),
      .cmp_o      (cmp_o[i])
    );
  end

  always_comb begin
    bus_rdata_o = '0;
    if (hit(bus_addr_i, A_CTRL)) bus_rdata_o = CNT_W'(ctrl_q);
    if (hit(bus_addr_i, A_CNT))  bus_rdata_o = cnt_q;
    if (hit(bus_addr_i, A_PER))  bus_rdata_o = per_sh;
    if (hit(bus_addr_i, A_DUTY)) bus_rdata_o = duty_sh;
    if (hit(bus_addr_i, A_STAT)) bus_rdata_o = CNT_W'({ch_ovr, ch_flag, ovf_q});
    if (hit(bus_addr_i, A_IEN))  bus_rdata_o = CNT_W'(ien_q);
    for (int i = 0; i < NUM_CH; i++) begin
      if (hit(bus_addr_i, A_CH0 + 2 * i))     bus_rdata_o = CNT_W'(ch_cfg[i]);
      if (hit(bus_addr_i, A_CH0 + 2 * i + 1)) bus_rdata_o = ch_val[i];
    end
  end

  assign pwm_o = pwm_mode && (cnt_q < duty_act);
  assign irq_o = |({ch_flag, ovf_q} & ien_q);

  AST_OVF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_evt |=> (ovf_q && cnt_q == '0)); // R3
  AST_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !cnt_we) |=> $stable(cnt_q)); // R2
  AST_PWM_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm_mode && !cnt_we && cnt_q <= per_act) |=> (cnt_q <= $past(per_act))); // R8
  AST_SHADOW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm_mode && !reload) |=> ($stable(per_act) && $stable(duty_act))); // R9
  AST_IRQ_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ien_q == '0) |-> !irq_o); // R10

endmodule

// File: tb/test_mct_timer.sv
module test_mct_timer;
  localparam int A_CTRL = 0, A_CNT = 1, A_PER = 2, A_DUTY = 3;
  localparam int A_C0CFG = 4, A_C0VAL = 5, A_C1CFG = 6, A_C1VAL = 7;
  localparam int A_STAT = 8, A_IEN = 9;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we;
  logic [3:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic [1:0]  cap, cmp;
  logic        pulse, pwm, irq;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mct_timer i_mct_timer (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .bus_we_i    (bus_we),
    .bus_addr_i  (bus_addr),
    .bus_wdata_i (bus_wdata),
    .bus_rdata_o (bus_rdata),
    .cap_i       (cap),
    .pulse_i     (pulse),
    .cmp_o       (cmp),
    .pwm_o       (pwm),
    .irq_o       (irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    bus_we = 1'b1; bus_addr = 4'(a); bus_wdata = 16'(d);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input int a, output logic [15:0] d);
    bus_addr = 4'(a);
    #1 d = bus_rdata;
  endtask

  function automatic int exp_ticks(input int m, input int p);
    return (m + 1) / (p + 1);
  endfunction

  // period 4 / duty 2 until the restart after k=4, then period 2 / duty 1
  function automatic logic exp_pwm(input int k);
    if (k < 5) return k < 2;
    return ((k - 5) % 3) < 1;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    int seed;
    seed = $urandom(32'h5EED);
    bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; cap = '0; pulse = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    rd(A_CNT, d);  chk("R1 count", d, 0);
    rd(A_STAT, d); chk("R1 status", d, 0);
    chk("R1 cmp_o", cmp, 0);
    chk("R1 pwm_o", pwm, 0);
    chk("R1 irq_o", irq, 0);

    // R2 prescaler: directed extremes then random divisors
    for (int it = 0; it < 8; it++) begin
      int p, m;
      p = (it == 0) ? 0 : (it == 1) ? 127 : int'($urandom % 128);
      m = int'($urandom % 400);
      wr(A_CTRL, 0);
      wr(A_CNT, 0);
      wr(A_CTRL, 1 | (p << 4));
      idle(m);
      wr(A_CTRL, 0);
      rd(A_CNT, d); chk("R2 prescaled count", d, exp_ticks(m, p));
      idle(20);
      rd(A_CNT, d); chk("R2 frozen while stopped", d, exp_ticks(m, p));
    end

    // R3 wrap and overflow flag, R10 masking, R11 write-one-to-clear
    wr(A_IEN, 1);
    wr(A_CNT, 16'hFFFE);
    wr(A_CTRL, 1);
    idle(1);
    rd(A_STAT, d); chk("R3 no flag before wrap", d & 1, 0);
    chk("R10 irq low before wrap", irq, 0);
    idle(2);
    rd(A_CNT, d);  chk("R3 count after wrap", d, 1);
    rd(A_STAT, d); chk("R3 overflow flag", d & 1, 1);
    chk("R10 irq on enabled overflow", irq, 1);
    wr(A_CTRL, 0);
    wr(A_IEN, 0);
    chk("R10 irq masked", irq, 0);
    wr(A_IEN, 1);
    wr(A_STAT, 0);
    rd(A_STAT, d); chk("R11 zero write keeps flag", d & 1, 1);
    wr(A_STAT, 1);
    rd(A_STAT, d); chk("R11 one write clears flag", d & 1, 0);
    chk("R10 irq after clear", irq, 0);

    // R4 pulse counting, rising then falling
    wr(A_CNT, 0);
    wr(A_CTRL, 5 | (5 << 4));
    for (int i = 0; i < 7; i++) begin
      pulse = 1'b1; idle(3);
      pulse = 1'b0; idle(3);
    end
    idle(4);
    rd(A_CNT, d); chk("R4 rising pulses", d, 7);
    wr(A_CTRL, 0);
    wr(A_CNT, 0);
    wr(A_CTRL, 13);
    for (int i = 0; i < 4; i++) begin
      pulse = 1'b1; idle(3);
      idle(1);
      rd(A_CNT, d); chk("R4 rising edge ignored in falling mode", d, i);
      pulse = 1'b0; idle(3);
    end
    idle(4);
    rd(A_CNT, d); chk("R4 falling pulses", d, 4);
    wr(A_CTRL, 0);

    // R5 capture on both channels, R6 overrun
    wr(A_CNT, 100);
    wr(A_C1CFG, 2);
    cap[1] = 1'b1;
    idle(5);
    rd(A_STAT, d); chk("R5 unselected edge ignored", d, 0);
    wr(A_CTRL, 1);
    idle(7);
    cap = 2'b01;
    idle(6);
    rd(A_C0VAL, d); chk("R5 rising capture value", d, 109);
    rd(A_C1VAL, d); chk("R5 falling capture value", d, 109);
    rd(A_STAT, d);  chk("R5 capture flags", d, 16'h6);
    cap[0] = 1'b0; idle(4);
    cap[0] = 1'b1; idle(5);
    rd(A_STAT, d);  chk("R6 overrun on second capture", d, 16'hE);
    wr(A_STAT, 16'hA);
    rd(A_STAT, d);  chk("R11 partial clear", d, 16'h4);
    wr(A_STAT, 16'h1F);
    wr(A_CTRL, 0);

    // R7 compare set / toggle / clear
    wr(A_CNT, 0);
    wr(A_C0CFG, 16'hD);
    wr(A_C0VAL, 10);
    wr(A_C1CFG, 16'h5);
    wr(A_C1VAL, 5);
    wr(A_CTRL, 1);
    idle(5);  chk("R7 set not before match", cmp[1], 0);
    idle(1);  chk("R7 set action", cmp[1], 1);
    idle(4);  chk("R7 toggle not before match", cmp[0], 0);
    idle(1);  chk("R7 toggle action", cmp[0], 1);
    rd(A_STAT, d); chk("R7 compare flags", d & 16'h6, 16'h6);
    wr(A_C1CFG, 16'h9);
    wr(A_C1VAL, 20);
    idle(12); chk("R7 clear action", cmp[1], 0);
    chk("R7 toggle pin holds", cmp[0], 1);
    wr(A_CTRL, 0);
    wr(A_C0CFG, 0);
    wr(A_C1CFG, 0);
    wr(A_STAT, 16'h1F);

    // R8 PWM waveform, R9 shadowed period/duty
    wr(A_CNT, 0);
    wr(A_PER, 4);
    wr(A_DUTY, 2);
    chk("R8 pwm low outside mode", pwm, 0);
    wr(A_CTRL, 3);
    chk("R8 pwm k=0", pwm, exp_pwm(0));
    wr(A_PER, 2);
    wr(A_DUTY, 1);
    for (int k = 2; k < 13; k++) begin
      chk((k < 5) ? "R9 old period kept" : "R8 new period applied", pwm, exp_pwm(k));
      idle(1);
    end
    wr(A_CTRL, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule